// File: doc/BRIEF.md
# Configuration Register File with Write Masks

This block holds the 256-byte configuration space of one bus function. A host-side decoder reaches it through a plain read/write port that carries a byte address, a 32-bit data word and an access length of 1, 2 or 4 bytes. Multi-byte accesses are little-endian: the byte at the access address is the least significant.

Every byte has a write-enable bit mask that is fixed when the block is built. A write can therefore change only the permitted bits of each byte it touches. The identity fields (vendor, device, revision, class code and header type) come from parameters and cannot be written. There are six base address registers and one expansion-ROM register. Each is given a power-of-two size through a parameter, so writing all ones and reading back reports the region size.

A one-cycle pulse tells the mapping logic that a write changed a base address register byte or one of the two decode-enable bits in the command register.

Top module: `cfg_space`

## Requirements
- R1: After reset, bytes 0x00-0x01 hold the vendor ID and bytes 0x02-0x03 hold the device ID. Byte 0x08 holds the revision, bytes 0x09-0x0B hold the class code (low byte first) and byte 0x0E holds the header type. Bit 0 of the low byte of each I/O base register reads 1. Every other byte reads 0, and the read data output reads 0.
- R2: Multi-byte reads and writes are little-endian. Data byte k (bits 8k+7..8k) maps to address addr+k.
- R3: A write sets each addressed byte to (old AND NOT mask) OR (data AND mask). Bytes with a zero mask, such as the identity fields, never change.
- R4: Write bytes that would fall beyond address 0xFF are dropped. The bytes that fit are still written.
- R5: A read returns 0xFFFFFFFF when len is 4 and addr is above 0xFC, or len is 2 and addr is above 0xFE, or len is not 1, 2 or 4. A write with a len other than 1, 2 or 4 changes nothing.
- R6: In the command byte 0x04 only bits 0 (I/O decode), 1 (memory decode) and 2 (bus master) are writable. Bytes 0x0C and 0x3C are fully writable.
- R7: Every byte from 0x40 to 0xFF is fully writable.
- R8: Base register n (n = 0..5) sits at 0x10+4n with mask NOT(2^k - 1), where k is its size exponent. When k is 0 the register is unused: it reads 0 and ignores writes.
- R9: The expansion-ROM register at 0x30 has mask NOT(2^k - 1) with bit 0, its enable bit, also writable.
- R10: map_chg is high for exactly the one cycle after a write that changed any byte in 0x10-0x27, or bit 0 or bit 1 of byte 0x04. A write that changes only other bits, or changes nothing, gives no pulse.
- R11: rdata is updated on the clock edge at which rd_en is high and holds at all other times. A read returns the contents from before a write in the same cycle. For reads of 1 or 2 bytes, the unused upper bytes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 8 | Byte address of the access |
| len | input | 3 | Access length in bytes (1, 2 or 4) |
| wdata | input | 32 | Write data, byte 0 goes to addr |
| rdata | output | 32 | Registered read data |
| map_chg | output | 1 | One-cycle pulse after a mapping-relevant change |

## Verification
The assertions watch four things on every cycle. The upper five command bits and the vendor byte stay constant. rdata holds whenever no read is issued, and out-of-range long reads return all ones. map_chg is only ever raised the cycle after a write. Only the bench's scenarios can show the size-probe readback values of each base and ROM register, the clipping of writes at the top of the space, and the little-endian byte placement. The same holds for the rule that a same-value write or a bus-master-only change produces no pulse.

// File: rtl/cfg_pkg.sv
package cfg_pkg;

    typedef struct packed {
        logic [31:0] rdata;
        logic        chg;
    } cfg_out_t;

    function automatic logic [31:0] cfg_size_mask(input logic [5:0] k);
        if (k == 6'd0) return 32'd0;
        return ~((32'd1 << k) - 32'd1);
    endfunction

    function automatic logic [7:0] cfg_mask(input int a, input logic [35:0] bar_log2,
                                            input logic [5:0] rom_log2);
        logic [7:0]  m;
        logic [31:0] w;
        int          n;
        int          b;
        m = 8'h00;
        if (a == 4) m = 8'h07;
        else if (a == 12 || a == 60 || a >= 64) m = 8'hFF;
        else if (a >= 16 && a < 40) begin
            n = (a - 16) / 4;
            b = (a - 16) % 4;
            w = cfg_size_mask(bar_log2[6*n +: 6]);
            m = w[8*b +: 8];
        end else if (a >= 48 && a < 52) begin
            w = cfg_size_mask(rom_log2);
            if (rom_log2 != 6'd0) w[0] = 1'b1;
            m = w[8*(a-48) +: 8];
        end
        return m;
    endfunction

    function automatic logic [7:0] cfg_init(input int a, input logic [15:0] vid,
                                            input logic [15:0] did, input logic [7:0] rev,
                                            input logic [23:0] cls, input logic [7:0] hdr,
                                            input logic [35:0] bar_log2, input logic [5:0] bar_io);
        logic [7:0] v;
        int         n;
        v = 8'h00;
        case (a)
            0:  v = vid[7:0];
            1:  v = vid[15:8];
            2:  v = did[7:0];
            3:  v = did[15:8];
            8:  v = rev;
            9:  v = cls[7:0];
            10: v = cls[15:8];
            11: v = cls[23:16];
            14: v = hdr;
            default: begin
                if (a >= 16 && a < 40 && ((a - 16) % 4) == 0) begin
                    n = (a - 16) / 4;
                    if (bar_log2[6*n +: 6] != 6'd0 && bar_io[n]) v = 8'h01;
                end
            end
        endcase
        return v;
    endfunction

endpackage

// File: rtl/cfg_lane.sv
module cfg_lane #(
    parameter int         IDX  = 0,
    parameter logic [7:0] MASK = 8'h00
) (
    input  logic        wr_en,
    input  logic        len_ok,
    input  logic [7:0]  addr,
    input  logic [2:0]  len,
    input  logic [31:0] wdata,
    input  logic [7:0]  old_byte,
    output logic [7:0]  new_byte
);
    localparam logic [8:0] POS = 9'(IDX);

    logic [8:0] off;
    logic       hit;
    logic [7:0] din;

    always_comb begin
        off      = POS - {1'b0, addr};
        hit      = wr_en && len_ok && (POS >= {1'b0, addr}) && (off < {6'd0, len});
        din      = wdata[{off[1:0], 3'b000} +: 8];
        new_byte = hit ? ((old_byte & ~MASK) | (din & MASK)) : old_byte;
    end
endmodule

// File: rtl/cfg_rd_mux.sv
module cfg_rd_mux #(
    parameter int DEPTH = 256
) (
    input  logic [7:0]  mem [DEPTH],
    input  logic [7:0]  addr,
    input  logic [2:0]  len,
    output logic [31:0] word
);
    logic       valid;
    logic [8:0] idx;

    always_comb begin
        valid = (len == 3'd1) || (len == 3'd2 && addr <= 8'hFE) ||
                (len == 3'd4 && addr <= 8'hFC);
        word  = 32'd0;
        for (int j = 0; j < 4; j++) begin
            idx = {1'b0, addr} + 9'(j);
            if (3'(j) < len && idx < 9'(DEPTH)) word[8*j +: 8] = mem[idx[7:0]];
        end
        if (!valid) word = 32'hFFFF_FFFF;
    end
endmodule

// File: rtl/cfg_space.sv
module cfg_space
    import cfg_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID  = 16'h1AB4,
    parameter logic [15:0] DEVICE_ID  = 16'h7C21,
    parameter logic [7:0]  REVISION   = 8'h03,
    parameter logic [23:0] CLASS_CODE = 24'h020000,
    parameter logic [7:0]  HDR_TYPE   = 8'h80,
    parameter logic [35:0] BAR_LOG2   = {6'd0, 6'd0, 6'd0, 6'd20, 6'd12, 6'd5},
    parameter logic [5:0]  BAR_IO     = 6'b000001,
    parameter logic [5:0]  ROM_LOG2   = 6'd16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic [7:0]  addr,
    input  logic [2:0]  len,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    output logic        map_chg
);
    localparam int DEPTH   = 256;
    localparam int CMD_OFS = 4;
    localparam int BAR_LO  = 16;
    localparam int BAR_HI  = BAR_LO + 6 * 4;

    logic [7:0] mem_q [DEPTH];
    logic [7:0] mem_d [DEPTH];
    cfg_out_t   st_q, st_d;
    logic [31:0] rd_word;
    logic        len_ok;

    assign len_ok = (len == 3'd1) || (len == 3'd2) || (len == 3'd4);

    for (genvar i = 0; i < DEPTH; i++) begin : g_lane
        cfg_lane #(
            .IDX (i),
            .MASK(cfg_mask(i, BAR_LOG2, ROM_LOG2))
        ) i_lane (
            .wr_en   (wr_en),
            .len_ok  (len_ok),
            .addr    (addr),
            .len     (len),
            .wdata   (wdata),
            .old_byte(mem_q[i]),
            .new_byte(mem_d[i])
        );
    end

    cfg_rd_mux #(.DEPTH(DEPTH)) i_rd_mux (
        .mem (mem_q),
        .addr(addr),
        .len (len),
        .word(rd_word)
    );

    always_comb begin
        st_d       = st_q;
        st_d.rdata = rd_en ? rd_word : st_q.rdata;
        st_d.chg   = (mem_d[CMD_OFS][1:0] != mem_q[CMD_OFS][1:0]);
        for (int i = BAR_LO; i < BAR_HI; i++) begin
            if (mem_d[i] != mem_q[i]) st_d.chg = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
            for (int i = 0; i < DEPTH; i++)
                mem_q[i] <= cfg_init(i, VENDOR_ID, DEVICE_ID, REVISION, CLASS_CODE,
                                     HDR_TYPE, BAR_LOG2, BAR_IO);
        end else begin
            st_q <= st_d;
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_d[i];
        end
    end

    assign rdata   = st_q.rdata;
    assign map_chg = st_q.chg;

    assert_ro_vendor_R3: assert property (@(posedge clk) disable iff (rst)
        $stable(mem_q[0]));
    assert_cmd_upper_R6: assert property (@(posedge clk) disable iff (rst)
        mem_q[CMD_OFS][7:3] == 5'd0);
    assert_oor_ones_R5: assert property (@(posedge clk) disable iff (rst)
        (rd_en && len == 3'd4 && addr > 8'hFC) |=> (rdata == 32'hFFFF_FFFF));
    assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rdata));
    assert_chg_cause_R10: assert property (@(posedge clk) disable iff (rst)
        map_chg |-> $past(wr_en));
endmodule

// File: tb/test_cfg_space.sv
`timescale 1ns/1ps
module test_cfg_space;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0]  addr = 8'd0;
    logic [2:0]  len = 3'd1;
    logic [31:0] wdata = 32'd0;
    logic [31:0] rdata;
    logic        map_chg;

    int total = 0, bad = 0;
    bit done = 0;
    int ref_mem [256];
    int exp_rdata = 0;
    bit exp_chg = 0;

    always #5 clk = ~clk;

    cfg_space i_cfg_space (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .len(len), .wdata(wdata), .rdata(rdata), .map_chg(map_chg)
    );

    function automatic int bar_k(input int n);
        case (n) 0: return 5; 1: return 12; 2: return 20; default: return 0; endcase
    endfunction

    function automatic int ref_mask(input int a);
        longint full;
        if (a == 4) return 7;
        if (a == 12 || a == 60 || a >= 64) return 255;
        if (a >= 16 && a < 40) begin
            if (bar_k((a-16)/4) == 0) return 0;
            full = 64'hFFFFFFFF - ((64'd1 << bar_k((a-16)/4)) - 1);
            return int'((full >> (8*((a-16)%4))) & 255);
        end
        if (a >= 48 && a < 52) begin
            full = (64'hFFFFFFFF - 65535) | 1;
            return int'((full >> (8*(a-48))) & 255);
        end
        return 0;
    endfunction

    task automatic model_reset();
        for (int a = 0; a < 256; a++) ref_mem[a] = 0;
        ref_mem[0] = 'hB4; ref_mem[1] = 'h1A; ref_mem[2] = 'h21; ref_mem[3] = 'h7C;
        ref_mem[8] = 'h03; ref_mem[11] = 'h02; ref_mem[14] = 'h80; ref_mem[16] = 'h01;
    endtask

    task automatic check(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%08h expected=%08h", req, what, act, exp);
        end
    endtask

    task automatic op(input string req, input bit w, input bit r, input int a,
                      input int l, input int d);
        int val, ad, m, old;
        bit ok;
        @(negedge clk);
        wr_en = w; rd_en = r; addr = 8'(a); len = 3'(l); wdata = d;
        @(posedge clk);
        #1;
        if (r) begin
            ok = (l == 1) || (l == 2 && a <= 254) || (l == 4 && a <= 252);
            val = 0;
            for (int j = 0; j < l && j < 4; j++)
                if (a + j < 256) val |= ref_mem[a+j] << (8*j);
            exp_rdata = ok ? val : 32'hFFFFFFFF;
        end
        exp_chg = 0;
        if (w && (l == 1 || l == 2 || l == 4)) begin
            for (int j = 0; j < l; j++) begin
                ad = a + j;
                if (ad < 256) begin
                    m = ref_mask(ad);
                    old = ref_mem[ad];
                    ref_mem[ad] = (old & ~m & 255) | ((d >> (8*j)) & m);
                    if (ad >= 16 && ad < 40 && old != ref_mem[ad]) exp_chg = 1;
                    if (ad == 4 && ((old ^ ref_mem[ad]) & 3) != 0) exp_chg = 1;
                end
            end
        end
        check(req, "rdata", int'(rdata), exp_rdata);
        check("R10", "map_chg", int'(map_chg), int'(exp_chg));
        wr_en = 0; rd_en = 0;
    endtask

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        #1;
        check("R1", "rdata after reset", int'(rdata), 0);
        check("R1", "map_chg after reset", int'(map_chg), 0);
        // R1 identity and type bits
        op("R1", 0, 1, 'h00, 4, 0);
        check("R1", "vendor/device", int'(rdata), 'h7C211AB4);
        op("R1", 0, 1, 'h08, 4, 0);
        op("R1", 0, 1, 'h0C, 4, 0);
        op("R1", 0, 1, 'h10, 4, 0);
        op("R1", 0, 1, 'h14, 4, 0);
        // R3 read-only identity
        op("R3", 1, 0, 'h00, 4, 'hFFFFFFFF);
        op("R3", 0, 1, 'h00, 4, 0);
        op("R3", 1, 0, 'h0E, 1, 'h55);
        op("R3", 0, 1, 'h0E, 1, 0);
        // R6 command byte
        op("R6", 1, 0, 'h04, 2, 'hFFFF);
        op("R6", 0, 1, 'h04, 2, 0);
        check("R6", "command", int'(rdata), 7);
        op("R10", 1, 0, 'h04, 1, 'h07);
        op("R10", 1, 0, 'h04, 1, 'h03);
        op("R10", 1, 0, 'h04, 1, 'h00);
        op("R6", 1, 0, 'h0C, 1, 'hA5);
        op("R6", 1, 0, 'h3C, 1, 'h0B);
        op("R6", 0, 1, 'h0C, 1, 0);
        op("R6", 0, 1, 'h3C, 1, 0);
        // R8 base register probing
        for (int n = 0; n < 6; n++) begin
            op("R8", 1, 0, 'h10 + 4*n, 4, 'hFFFFFFFF);
            op("R8", 0, 1, 'h10 + 4*n, 4, 0);
        end
        op("R8", 0, 1, 'h10, 4, 0);
        check("R8", "io bar probe", int'(rdata), 'hFFFFFFE1);
        op("R8", 1, 0, 'h14, 4, 'hFFFFFFFF);
        op("R8", 1, 0, 'h14, 4, 'h12345000);
        op("R8", 0, 1, 'h14, 4, 0);
        // R9 ROM
        op("R9", 1, 0, 'h30, 4, 'hFFFFFFFF);
        op("R9", 0, 1, 'h30, 4, 0);
        check("R9", "rom probe", int'(rdata), 'hFFFF0001);
        // R2 R7 little endian in open area
        op("R7", 1, 0, 'h40, 4, 'h11223344);
        op("R2", 0, 1, 'h41, 1, 0);
        op("R2", 0, 1, 'h42, 2, 0);
        check("R2", "halfword", int'(rdata), 'h1122);
        op("R7", 1, 0, 'h81, 2, 'hBEEF);
        op("R7", 0, 1, 'h80, 4, 0);
        // R4 clipping
        op("R4", 1, 0, 'hFE, 4, 'hAABBCCDD);
        op("R4", 0, 1, 'hFF, 1, 0);
        check("R4", "last byte", int'(rdata), 'hCC);
        op("R4", 0, 1, 'hFC, 4, 0);
        op("R4", 0, 1, 'h00, 1, 0);
        // R5 range and bad length
        op("R5", 0, 1, 'hFD, 4, 0);
        op("R5", 0, 1, 'hFF, 2, 0);
        op("R5", 0, 1, 'hFE, 2, 0);
        op("R5", 0, 1, 'h40, 3, 0);
        op("R5", 1, 0, 'h40, 3, 'h0);
        op("R5", 0, 1, 'h40, 4, 0);
        check("R5", "bad len write ignored", int'(rdata), 'h11223344);
        // R11 read-before-write and hold
        op("R11", 1, 1, 'h50, 4, 'hCAFEF00D);
        op("R11", 0, 0, 'h00, 1, 0);
        op("R11", 0, 0, 'h10, 4, 0);
        op("R11", 0, 1, 'h50, 4, 0);
        check("R11", "written word", int'(rdata), 'hCAFEF00D);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog R11: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule